// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the tag side of a set-associative cache: for every way of every set it records which line address is resident, how that line may be used, and which context, if any, holds a reservation on it. A cache controller sends it one command per cycle: lookup, permission-checked access, availability query, allocation, deallocation, victim probe, permission update, and lock set, clear or test. It answers each one with hit, way, grant, victim address and error flags. Data storage and the coherence protocol live outside. The protocol drives line permissions through the permission-update command.

The set is picked by a field of the line address. A bit-per-way recency tracker in each set picks the line to evict when the set is full. Commands use a valid/ready handshake. The response is registered and held until the consumer takes it.

Top module: `tag_directory`

## Requirements
- R1: The number of sets is CACHE_BYTES / WAYS / LINE_BYTES, a power of two no smaller than 2. The set index is the line-address field starting at bit SET_LSB, $clog2(sets) bits wide. Lines whose index fields differ never compete for ways.
- R2: Command codes on `cmd_op`: 0 lookup, 1 access, 2 availability, 3 allocate, 4 deallocate, 5 probe, 6 set permission, 7 set lock, 8 clear lock, 9 test lock. Any other code gives an error response. A lookup hits only on a way that is occupied, holds the full line address, and has a permission other than NotPresent. It then reports that way and sets grant.
- R3: Permission codes: 0 NotPresent, 1 Invalid, 2 ReadOnly, 3 ReadWrite, 4 Busy. Request codes on `cmd_req`: 0 load, 1 instruction fetch, 2 store. An access is granted on a hit to ReadWrite for any request type, and on a hit to ReadOnly for load or fetch only. Every other case is refused, while hit still reports the match.
- R4: Every hitting lookup or access marks the matched way as recently used, even when the access is refused.
- R5: Availability grants when the address is present in its set or some way of the set is empty or NotPresent.
- R6: Allocation fills the lowest-numbered way that is empty or NotPresent, reports that way and grants. The new line starts Invalid with no lock owner. Its recency bit is set only when `cmd_touch` is high.
- R7: Allocating an address already present, or into a set with no free way, raises `rsp_error`, withholds grant and changes no state.
- R8: Deallocation of a present address empties its way. If the address is absent, the response is an error.
- R9: Each set keeps one recency bit per way. A touch sets the touched bit; if that would set every bit, only the touched bit remains. A probe on a full set returns, in `rsp_victim` and `rsp_way`, the lowest way whose bit is clear. A probe on a set with a free way is an error.
- R10: Set permission writes `cmd_perm` into the matched line. If no line matches, the response is an error.
- R11: Set lock stores `cmd_ctx` as owner of the matched line, and clear lock removes the owner. Test lock grants only when an owner is stored and equals `cmd_ctx`. All three are errors on a miss.
- R12: After reset every way is empty, all recency bits are clear and no response is pending.
- R13: `cmd_ready` is high when no response is held or `rsp_ready` is high. An accepted command's response appears on the next cycle and is held stable until taken.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 4 | Command code (R2) |
| cmd_addr | input | ADDR_W | Line address |
| cmd_req | input | 2 | Request type for access (R3) |
| cmd_perm | input | 3 | Permission for set-permission (R3) |
| cmd_ctx | input | CTX_W | Context for lock commands |
| cmd_touch | input | 1 | Allocation updates recency |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Address matched a present line |
| rsp_way | output | WAY_W | Matched, allocated or victim way |
| rsp_grant | output | 1 | Command-specific grant |
| rsp_error | output | 1 | Command could not be performed |
| rsp_victim | output | ADDR_W | Victim line address from a probe |

## Verification
On every cycle, the assertions check several properties. No address is ever present in two ways of a set. At most one way is touched, and only by an accepted command. Responses follow acceptance by one cycle and stay stable under back-pressure. An access or lock-test grant never comes without a hit, and a refused allocation never grants. Only the directed scenarios can show the values themselves: which way allocation picks, the permission-versus-request grant table, the recency sequence and its wrap seen through successive probes, the touch flag's effect on the victim, lock ownership across reallocation, and that a refused command left the directory unchanged.

// File: rtl/tdir_pkg.sv
`timescale 1ns/1ps
package tdir_pkg;

  localparam logic [2:0] PERM_ABSENT  = 3'd0;
  localparam logic [2:0] PERM_INVALID = 3'd1;
  localparam logic [2:0] PERM_RO      = 3'd2;
  localparam logic [2:0] PERM_RW      = 3'd3;
  localparam logic [2:0] PERM_BUSY    = 3'd4;

  localparam logic [1:0] REQ_LOAD  = 2'd0;
  localparam logic [1:0] REQ_FETCH = 2'd1;
  localparam logic [1:0] REQ_STORE = 2'd2;

  localparam logic [3:0] OP_LOOKUP   = 4'd0;
  localparam logic [3:0] OP_ACCESS   = 4'd1;
  localparam logic [3:0] OP_AVAIL    = 4'd2;
  localparam logic [3:0] OP_ALLOC    = 4'd3;
  localparam logic [3:0] OP_DEALLOC  = 4'd4;
  localparam logic [3:0] OP_PROBE    = 4'd5;
  localparam logic [3:0] OP_SETPERM  = 4'd6;
  localparam logic [3:0] OP_LOCKSET  = 4'd7;
  localparam logic [3:0] OP_LOCKCLR  = 4'd8;
  localparam logic [3:0] OP_LOCKTEST = 4'd9;

  // Grant rule for a permission-checked access on a hitting line (R3)
  function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] req);
    if (perm == PERM_RW) return 1'b1;
    if (perm == PERM_RO) return (req == REQ_LOAD) || (req == REQ_FETCH);
    return 1'b0;
  endfunction

  // Recency update: set touched bit, collapse to the touched bit when full (R9)
  function automatic logic [63:0] recency_next(input logic [63:0] cur, input logic [63:0] oh,
                                               input logic [63:0] all_ones);
    logic [63:0] merged;
    merged = cur | oh;
    return (merged == all_ones) ? oh : merged;
  endfunction

endpackage

// File: rtl/tdir_store.sv
`timescale 1ns/1ps
module tdir_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int CTX_W  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SET_W-1:0]                  rd_set,
  output logic [WAYS-1:0]                   rd_occ,
  output logic [WAYS-1:0][ADDR_W-1:0]       rd_addr,
  output logic [WAYS-1:0][2:0]              rd_perm,
  output logic [WAYS-1:0]                   rd_lkh,
  output logic [WAYS-1:0][CTX_W-1:0]        rd_lko,
  input  logic                              wr_en,
  input  logic [SET_W-1:0]                  wr_set,
  input  logic [WAY_W-1:0]                  wr_way,
  input  logic                              wr_occ,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [2:0]                        wr_perm,
  input  logic                              wr_lkh,
  input  logic [CTX_W-1:0]                  wr_lko
);

  logic [WAYS-1:0]             occ_q  [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] addr_q [SETS];
  logic [WAYS-1:0][2:0]        perm_q [SETS];
  logic [WAYS-1:0]             lkh_q  [SETS];
  logic [WAYS-1:0][CTX_W-1:0]  lko_q  [SETS];

  // Occupancy and lock-held bits carry reset (R12); payload fields do not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        occ_q[s] <= '0;
        lkh_q[s] <= '0;
      end
    end else if (wr_en) begin
      occ_q[wr_set][wr_way] <= wr_occ;
      lkh_q[wr_set][wr_way] <= wr_lkh;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_set][wr_way] <= wr_addr;
      perm_q[wr_set][wr_way] <= wr_perm;
      lko_q[wr_set][wr_way]  <= wr_lko;
    end
  end

  assign rd_occ  = occ_q[rd_set];
  assign rd_addr = addr_q[rd_set];
  assign rd_perm = perm_q[rd_set];
  assign rd_lkh  = lkh_q[rd_set];
  assign rd_lko  = lko_q[rd_set];

endmodule

// File: rtl/tdir_match.sv
`timescale 1ns/1ps
module tdir_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             occ,
  input  logic [WAYS-1:0][ADDR_W-1:0] way_addr,
  input  logic [WAYS-1:0][2:0]        perm,
  input  logic [ADDR_W-1:0]           addr,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             free_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free_any,
  output logic [WAY_W-1:0]            free_way
);
  import tdir_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]  = occ[w] && (way_addr[w] == addr) && (perm[w] != PERM_ABSENT);
    assign free_vec[w] = !occ[w] || (perm[w] == PERM_ABSENT);
  end

  assign hit      = |hit_vec;
  assign free_any = |free_vec;

  // Scan from the top so the lowest-numbered way wins
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tdir_recency.sv
`timescale 1ns/1ps
module tdir_recency #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  touch_vec,
  input  logic [SET_W-1:0] touch_set,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  import tdir_pkg::*;

  localparam logic [63:0] ALL_ONES = (64'd1 << WAYS) - 64'd1;

  logic [WAYS-1:0] mru_q [SETS];
  logic [WAYS-1:0] mru_nxt;
  logic [63:0]     nxt_wide;

  always_comb begin
    nxt_wide = recency_next(64'(mru_q[touch_set]), 64'(touch_vec), ALL_ONES);
    mru_nxt  = nxt_wide[WAYS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else if (|touch_vec) begin
      mru_q[touch_set] <= mru_nxt;
    end
  end

  // Victim is the lowest way whose recency bit is clear (R9)
  always_comb begin
    vic_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!mru_q[vic_set][w]) vic_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tag_directory.sv
`timescale 1ns/1ps
module tag_directory #(
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 16,
  parameter int SET_LSB     = 2,
  parameter int CTX_W       = 4,
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_req,
  input  logic [2:0]        cmd_perm,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_touch,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_grant,
  output logic              rsp_error,
  output logic [ADDR_W-1:0] rsp_victim
);
  import tdir_pkg::*;

  // Set index field of the line address (R1)
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[SET_LSB +: SET_W];
  endfunction

  // Named internal events, observed by the bound checker
  logic              accept;
  logic [SET_W-1:0]  cur_set;
  logic [WAYS-1:0]   hit_vec, free_vec, touch_vec;
  logic              hit, free_any, wr_fire;
  logic [WAY_W-1:0]  hit_way, free_way, vic_way;
  logic [3:0]        rsp_op_q;

  logic [WAYS-1:0]             rd_occ, rd_lkh;
  logic [WAYS-1:0][ADDR_W-1:0] rd_addr;
  logic [WAYS-1:0][2:0]        rd_perm;
  logic [WAYS-1:0][CTX_W-1:0]  rd_lko;

  logic              wr_en, wr_occ, wr_lkh;
  logic [WAY_W-1:0]  wr_way;
  logic [ADDR_W-1:0] wr_addr;
  logic [2:0]        wr_perm;
  logic [CTX_W-1:0]  wr_lko;
  logic              touch_en;
  logic [WAY_W-1:0]  touch_way;

  logic              n_hit, n_grant, n_err;
  logic [WAY_W-1:0]  n_way;
  logic [ADDR_W-1:0] n_victim;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign cur_set   = set_of(cmd_addr);

  tdir_store #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(cur_set),
    .rd_occ(rd_occ), .rd_addr(rd_addr), .rd_perm(rd_perm), .rd_lkh(rd_lkh), .rd_lko(rd_lko),
    .wr_en(wr_fire), .wr_set(cur_set), .wr_way(wr_way), .wr_occ(wr_occ),
    .wr_addr(wr_addr), .wr_perm(wr_perm), .wr_lkh(wr_lkh), .wr_lko(wr_lko)
  );

  tdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .occ(rd_occ), .way_addr(rd_addr), .perm(rd_perm), .addr(cmd_addr),
    .hit_vec(hit_vec), .free_vec(free_vec), .hit(hit), .hit_way(hit_way),
    .free_any(free_any), .free_way(free_way)
  );

  tdir_recency #(.SETS(SETS), .WAYS(WAYS)) u_recency (
    .clk(clk), .rst_n(rst_n), .touch_vec(touch_vec), .touch_set(cur_set),
    .vic_set(cur_set), .vic_way(vic_way)
  );

  // Command decode: next entry contents, recency touch, response fields
  always_comb begin
    wr_en     = 1'b0;
    wr_way    = hit_way;
    wr_occ    = rd_occ[hit_way];
    wr_addr   = rd_addr[hit_way];
    wr_perm   = rd_perm[hit_way];
    wr_lkh    = rd_lkh[hit_way];
    wr_lko    = rd_lko[hit_way];
    touch_en  = 1'b0;
    touch_way = hit_way;
    n_hit     = hit;
    n_way     = hit_way;
    n_grant   = 1'b0;
    n_err     = 1'b0;
    n_victim  = '0;
    case (cmd_op)
      OP_LOOKUP: begin
        n_grant  = hit;
        touch_en = hit;
      end
      OP_ACCESS: begin
        n_grant  = hit && perm_allows(rd_perm[hit_way], cmd_req);
        touch_en = hit;
      end
      OP_AVAIL: n_grant = hit || free_any;
      OP_ALLOC: begin
        if (hit || !free_any) begin
          n_err = 1'b1;
        end else begin
          wr_en     = 1'b1;
          wr_way    = free_way;
          wr_occ    = 1'b1;
          wr_addr   = cmd_addr;
          wr_perm   = PERM_INVALID;
          wr_lkh    = 1'b0;
          wr_lko    = '0;
          touch_en  = cmd_touch;
          touch_way = free_way;
          n_way     = free_way;
          n_grant   = 1'b1;
        end
      end
      OP_DEALLOC: begin
        if (hit) begin
          wr_en  = 1'b1;
          wr_occ = 1'b0;
          wr_lkh = 1'b0;
        end else begin
          n_err = 1'b1;
        end
      end
      OP_PROBE: begin
        if (free_any) begin
          n_err = 1'b1;
        end else begin
          n_way    = vic_way;
          n_victim = rd_addr[vic_way];
          n_grant  = 1'b1;
        end
      end
      OP_SETPERM: begin
        if (hit) begin
          wr_en   = 1'b1;
          wr_perm = cmd_perm;
        end else begin
          n_err = 1'b1;
        end
      end
      OP_LOCKSET: begin
        if (hit) begin
          wr_en  = 1'b1;
          wr_lkh = 1'b1;
          wr_lko = cmd_ctx;
        end else begin
          n_err = 1'b1;
        end
      end
      OP_LOCKCLR: begin
        if (hit) begin
          wr_en  = 1'b1;
          wr_lkh = 1'b0;
          wr_lko = '0;
        end else begin
          n_err = 1'b1;
        end
      end
      OP_LOCKTEST: begin
        if (hit) n_grant = rd_lkh[hit_way] && (rd_lko[hit_way] == cmd_ctx);
        else     n_err   = 1'b1;
      end
      default: n_err = 1'b1;
    endcase
  end

  assign wr_fire   = accept && wr_en;
  assign touch_vec = (accept && touch_en) ? (WAYS'(1) << touch_way) : '0;

  // Registered response held until taken (R13)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_grant  <= 1'b0;
      rsp_error  <= 1'b0;
      rsp_victim <= '0;
      rsp_op_q   <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= n_hit;
      rsp_way    <= n_way;
      rsp_grant  <= n_grant;
      rsp_error  <= n_err;
      rsp_victim <= n_victim;
      rsp_op_q   <= cmd_op;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/tdir_checker.sv
`timescale 1ns/1ps
module tdir_checker #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_grant,
  input logic              rsp_error,
  input logic [WAY_W-1:0]  rsp_way,
  input logic [ADDR_W-1:0] rsp_victim,
  input logic [3:0]        rsp_op,
  input logic [WAYS-1:0]   hit_vec,
  input logic [WAYS-1:0]   touch_vec
);
  import tdir_pkg::*;

  assert_rsp_follows_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_rsp_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_grant) &&
                                   $stable(rsp_error) && $stable(rsp_way) && $stable(rsp_victim)));

  assert_no_duplicate_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_single_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(touch_vec));

  assert_touch_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|touch_vec) |-> accept);

  assert_access_grant_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op == OP_ACCESS && rsp_grant) |-> rsp_hit);

  assert_alloc_refused_nogrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op == OP_ALLOC && rsp_error) |-> !rsp_grant);

  assert_lock_grant_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op == OP_LOCKTEST && rsp_grant) |-> rsp_hit);

endmodule

bind tag_directory tdir_checker #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_tdir_checker (
  .clk(clk), .rst_n(rst_n), .accept(accept), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_grant(rsp_grant), .rsp_error(rsp_error), .rsp_way(rsp_way),
  .rsp_victim(rsp_victim), .rsp_op(rsp_op_q), .hit_vec(hit_vec), .touch_vec(touch_vec)
);

// File: tb/tag_directory_bench.sv
`timescale 1ns/1ps
module tag_directory_bench;

  localparam int ADDR_W = 16;
  localparam int CTX_W  = 4;

  localparam int LOOKUP = 0, ACCESS = 1, AVAIL = 2, ALLOC = 3, DEALLOC = 4, PROBE = 5,
                 SETPERM = 6, LOCKSET = 7, LOCKCLR = 8, LOCKTEST = 9;
  localparam int LD = 0, IF = 1, ST = 2;
  localparam int P_NP = 0, P_RO = 2, P_RW = 3, P_BUSY = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [3:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [1:0]        cmd_req = '0;
  logic [2:0]        cmd_perm = '0;
  logic [CTX_W-1:0]  cmd_ctx = '0;
  logic              cmd_touch = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic              rsp_hit, rsp_grant, rsp_error;
  logic [1:0]        rsp_way;
  logic [ADDR_W-1:0] rsp_victim;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tag_directory u_tag_directory (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
    .cmd_ctx(cmd_ctx), .cmd_touch(cmd_touch), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_grant(rsp_grant), .rsp_error(rsp_error),
    .rsp_victim(rsp_victim)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one command and return with the response visible
  task automatic issue(input int op, input int addr, input int req = 0, input int perm = 0,
                       input int ctx = 0, input bit touch = 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_addr  = ADDR_W'(addr);
    cmd_req   = 2'(req);
    cmd_perm  = 3'(perm);
    cmd_ctx   = CTX_W'(ctx);
    cmd_touch = touch;
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_eq("R13 response valid", 32'(rsp_valid), 1);
  endtask

  task automatic t_reset;
    expect_eq("R12 no response after reset", 32'(rsp_valid), 0);
    expect_eq("R13 ready after reset", 32'(cmd_ready), 1);
    issue(LOOKUP, 'h004);
    expect_eq("R12 empty after reset", 32'(rsp_hit), 0);
    issue(AVAIL, 'h004);
    expect_eq("R12 R5 set free after reset", 32'(rsp_grant), 1);
  endtask

  task automatic t_alloc_perm;
    issue(ALLOC, 'h004, 0, 0, 0, 1'b0);
    expect_eq("R6 first way", 32'(rsp_way), 0);
    expect_eq("R6 grant", 32'(rsp_grant), 1);
    issue(ALLOC, 'h014, 0, 0, 0, 1'b1);
    expect_eq("R6 next lowest way", 32'(rsp_way), 1);
    issue(ALLOC, 'h004);
    expect_eq("R7 duplicate alloc error", 32'(rsp_error), 1);
    expect_eq("R7 duplicate alloc no grant", 32'(rsp_grant), 0);
    issue(LOOKUP, 'h004);
    expect_eq("R2 lookup hit", 32'(rsp_hit), 1);
    expect_eq("R2 lookup way", 32'(rsp_way), 0);
    issue(LOOKUP, 'h005);
    expect_eq("R2 full address compared", 32'(rsp_hit), 0);
    issue(ACCESS, 'h004, LD);
    expect_eq("R6 new line Invalid refuses load", 32'(rsp_grant), 0);
    expect_eq("R3 refused access still hits", 32'(rsp_hit), 1);
    issue(SETPERM, 'h004, 0, P_RO);
    issue(ACCESS, 'h004, LD);
    expect_eq("R3 ReadOnly load", 32'(rsp_grant), 1);
    issue(ACCESS, 'h004, IF);
    expect_eq("R3 ReadOnly fetch", 32'(rsp_grant), 1);
    issue(ACCESS, 'h004, ST);
    expect_eq("R3 ReadOnly store refused", 32'(rsp_grant), 0);
    issue(SETPERM, 'h004, 0, P_RW);
    issue(ACCESS, 'h004, ST);
    expect_eq("R3 R10 ReadWrite store", 32'(rsp_grant), 1);
    issue(SETPERM, 'h004, 0, P_BUSY);
    issue(ACCESS, 'h004, LD);
    expect_eq("R3 Busy load refused", 32'(rsp_grant), 0);
    issue(SETPERM, 'h074, 0, P_RW);
    expect_eq("R10 set permission miss", 32'(rsp_error), 1);
    issue(SETPERM, 'h014, 0, P_NP);
    issue(LOOKUP, 'h014);
    expect_eq("R2 NotPresent is a miss", 32'(rsp_hit), 0);
    issue(ALLOC, 'h024);
    expect_eq("R6 reuse NotPresent way", 32'(rsp_way), 1);
    expect_eq("R6 reuse no error", 32'(rsp_error), 0);
  endtask

  task automatic t_victim;
    issue(ALLOC, 'h008); issue(ALLOC, 'h018); issue(ALLOC, 'h028); issue(ALLOC, 'h038);
    expect_eq("R6 fourth way", 32'(rsp_way), 3);
    issue(AVAIL, 'h048);
    expect_eq("R5 full set unavailable", 32'(rsp_grant), 0);
    issue(AVAIL, 'h018);
    expect_eq("R5 present line available", 32'(rsp_grant), 1);
    issue(ALLOC, 'h048);
    expect_eq("R7 full set alloc error", 32'(rsp_error), 1);
    issue(LOOKUP, 'h048);
    expect_eq("R7 state unchanged", 32'(rsp_hit), 0);
    issue(PROBE, 'h048);
    expect_eq("R9 victim initial", 32'(rsp_victim), 'h008);
    expect_eq("R9 victim way", 32'(rsp_way), 0);
    issue(LOOKUP, 'h008);
    issue(PROBE, 'h048);
    expect_eq("R4 lookup touches", 32'(rsp_victim), 'h018);
    issue(ACCESS, 'h018, ST);
    expect_eq("R3 Invalid store refused", 32'(rsp_grant), 0);
    issue(PROBE, 'h048);
    expect_eq("R4 refused access touches", 32'(rsp_victim), 'h028);
    issue(LOOKUP, 'h028); issue(LOOKUP, 'h038);
    issue(PROBE, 'h048);
    expect_eq("R9 recency collapse", 32'(rsp_victim), 'h008);
    issue(DEALLOC, 'h018);
    expect_eq("R8 dealloc hit", 32'(rsp_hit), 1);
    expect_eq("R8 dealloc no error", 32'(rsp_error), 0);
    issue(LOOKUP, 'h018);
    expect_eq("R8 line gone", 32'(rsp_hit), 0);
    issue(PROBE, 'h048);
    expect_eq("R9 probe with free way", 32'(rsp_error), 1);
    issue(ALLOC, 'h048, 0, 0, 0, 1'b1);
    expect_eq("R8 freed way reused", 32'(rsp_way), 1);
    issue(DEALLOC, 'h058);
    expect_eq("R8 dealloc absent", 32'(rsp_error), 1);
    issue(ALLOC, 'h00C, 0, 0, 0, 1'b1);
    issue(ALLOC, 'h01C); issue(ALLOC, 'h02C); issue(ALLOC, 'h03C);
    issue(PROBE, 'h04C);
    expect_eq("R6 touch flag sets recency", 32'(rsp_victim), 'h01C);
  endtask

  task automatic t_locks;
    issue(ALLOC, 'h000);
    issue(LOCKTEST, 'h000, 0, 0, 3);
    expect_eq("R6 no owner after alloc", 32'(rsp_grant), 0);
    issue(LOCKSET, 'h000, 0, 0, 3);
    issue(LOCKTEST, 'h000, 0, 0, 3);
    expect_eq("R11 owner matches", 32'(rsp_grant), 1);
    issue(LOCKTEST, 'h000, 0, 0, 5);
    expect_eq("R11 other context", 32'(rsp_grant), 0);
    issue(LOCKCLR, 'h000);
    issue(LOCKTEST, 'h000, 0, 0, 3);
    expect_eq("R11 cleared", 32'(rsp_grant), 0);
    issue(LOCKSET, 'h010, 0, 0, 3);
    expect_eq("R11 lock miss error", 32'(rsp_error), 1);
    issue(LOCKSET, 'h000, 0, 0, 7);
    issue(DEALLOC, 'h000);
    issue(ALLOC, 'h000);
    issue(LOCKTEST, 'h000, 0, 0, 7);
    expect_eq("R6 realloc clears owner", 32'(rsp_grant), 0);
    issue(ALLOC, 'h001);
    expect_eq("R1 set zero independent of full sets", 32'(rsp_way), 1);
    issue(11, 'h000);
    expect_eq("R2 unknown code error", 32'(rsp_error), 1);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 4'(LOOKUP); cmd_addr = 'h001;
    @(negedge clk);
    expect_eq("R13 response after one cycle", 32'(rsp_valid), 1);
    expect_eq("R13 not ready while held", 32'(cmd_ready), 0);
    cmd_op = 4'(ALLOC); cmd_addr = 'h011;
    repeat (2) @(negedge clk);
    expect_eq("R13 response held", 32'(rsp_valid), 1);
    expect_eq("R13 held value stable", 32'(rsp_hit), 1);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    expect_eq("R13 response released", 32'(rsp_valid), 0);
    issue(LOOKUP, 'h011);
    expect_eq("R13 blocked command ignored", 32'(rsp_hit), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_perm();
    t_victim();
    t_locks();
    t_handshake();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule